// File: doc/BRIEF.md
# Configurable SPI Master Shifter

This block is a serial peripheral interface master that exchanges one byte in each direction per transfer. Writing a byte while the block is idle launches the transfer in the next cycle; the block owns the serial clock, so no handshake with the far side is needed. The byte goes out most significant bit first, and the byte coming in is assembled the same way. When the byte is complete it lands in a receive buffer and an interrupt flag is raised.

Three static controls shape the waveform. The first sets the level at which the serial clock rests. The second picks whether the first output bit is presented before the first clock edge, with later bits changing as the clock returns to rest, or on the first clock edge, with later bits changing as the clock leaves rest. The third moves the input sample point from the middle of each output bit to its end. A two-bit selector sets the bit rate: three fixed divisions of the system clock or one clock level change per pulse of an external timer tick. A receive-only control releases the output enable while the shifting goes on as usual.

Top module: `spim_master`

## Requirements
- R1: A write strobe while idle starts a transfer: `busy` is high in the cycle after the strobe and stays high until the received byte is stored; the write does not alter `rd_data`.
- R2: The serial clock changes level every 2, 8 or 32 system clocks for rate codes 0, 1 and 2, and on every `tmr_tick` pulse for rate code 3, so one serial clock period is two ticks.
- R3: While `busy` is low, `sclk` equals `cfg_cpol`; every transfer makes exactly 16 serial clock level changes and leaves the clock at that level.
- R4: With `cfg_early` = 1, `sdo` shows bit 7 in the cycle after the write strobe, and each later bit appears on a change of `sclk` back to the rest level.
- R5: With `cfg_early` = 0, `sdo` keeps its previous value until the first clock change away from rest, where bit 7 appears; later bits appear on changes away from rest; after any transfer `sdo` holds bit 0 of the sent byte.
- R6: `sdi` is sampled in the middle of each output bit when `cfg_smp_end` = 0 and at its end when `cfg_smp_end` = 1; with `cfg_early` = 0 and end sampling, bit 0 is sampled one half period after the last clock change.
- R7: Both `sdo` and `sdi` carry bit 7 first and bit 0 last.
- R8: At the end of a transfer, if the buffer was empty, the received byte appears on `rd_data`, `busy` falls and `irq` rises in the same cycle.
- R9: A write strobe while `busy` is high is ignored (the byte on the line is unchanged) and sets `wcol`.
- R10: A byte that completes while the buffer still holds an unread byte sets `ovf` and leaves `rd_data` at the older byte; `rd_en` empties the buffer.
- R11: `irq`, `wcol` and `ovf` are low after reset and stay set until their own clear strobe (`irq_clr`, `wcol_clr`, `ovf_clr`); a set in the same cycle wins over a clear.
- R12: With `cfg_rx_only` = 1, `sdo_oe` is low and the transfer still receives a full byte at the selected rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_cpol | input | 1 | Serial clock rest level |
| cfg_early | input | 1 | 1: bit 7 before the first clock edge; 0: bit 7 on the first edge |
| cfg_smp_end | input | 1 | 0: sample mid-bit; 1: sample at end of bit |
| cfg_rate | input | 2 | Rate code: 0 /4, 1 /16, 2 /64, 3 timer tick based |
| cfg_rx_only | input | 1 | Release the output enable |
| tmr_tick | input | 1 | One-cycle pulses from an external timer |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to send |
| rd_en | input | 1 | Read strobe, empties the receive buffer |
| irq_clr | input | 1 | Clears `irq` |
| wcol_clr | input | 1 | Clears `wcol` |
| ovf_clr | input | 1 | Clears `ovf` |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| rd_data | output | 8 | Receive buffer |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Byte complete flag |
| wcol | output | 1 | Write collision flag |
| ovf | output | 1 | Receive overflow flag |

## Verification
The bench plays a slave that captures `sdo` on the edges where the line is stable for the chosen mode and moves `sdi` to its next bit only right after the edge on which the master should sample, so a master that samples on the wrong edge or a half period late receives a shifted byte. All four combinations of output timing and sample point are run with bytes whose adjacent bits differ (0xA5, 0x3C) and with random bytes, separating MSB-first from LSB-first order and catching off-by-one shifts. Each rate code is run and the spacing of the first two clock changes is measured, which tells the three dividers and the timer path apart. Directed cases cover a write in mid-transfer, two bytes without a read in between, and receive-only operation.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    RATE_DIV4  = 2'd0,
    RATE_DIV16 = 2'd1,
    RATE_DIV64 = 2'd2,
    RATE_TMR   = 2'd3
  } rate_e;
endpackage

// File: rtl/spim_clkgen.sv
// Produces one-cycle step pulses, one per half period of the serial clock.
module spim_clkgen
  import spim_pkg::*;
#(
  parameter int HALF_A = 2,
  parameter int HALF_B = 8,
  parameter int HALF_C = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e rate,
  input  logic  tmr_tick,
  output logic  step
);
  localparam int CW = $clog2(HALF_C + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          hit;

  always_comb begin
    case (rate)
      RATE_DIV4:  limit = CW'(HALF_A - 1);
      RATE_DIV16: limit = CW'(HALF_B - 1);
      default:    limit = CW'(HALF_C - 1);
    endcase
    hit   = (cnt_q == limit);
    step  = run && ((rate == RATE_TMR) ? tmr_tick : hit);
    cnt_d = (!run || hit || rate == RATE_TMR) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: fixed dividers never give steps in back-to-back cycles
  p_step_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rate != RATE_TMR) |=> !step);
endmodule

// File: rtl/spim_shifter.sv
// Step counter, serial clock phase, transmit and receive shift registers.
module spim_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx_load,
  input  logic         step,
  input  logic         cpol,
  input  logic         early,
  input  logic         smp_end,
  input  logic         sdi,
  output logic         run,
  output logic         sclk,
  output logic         sdo,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int STEPS = 2 * W;
  localparam int KW    = $clog2(STEPS + 1);

  logic          run_q, run_d, act_q, act_d, sdo_q, sdo_d;
  logic [KW-1:0] k_q, k_d, last;
  logic [W-1:0]  tx_q, tx_d, rx_q, rx_d, rx_next;
  logic          lead, tog, shift_ev, samp_ev;

  always_comb begin
    lead     = ~k_q[0];
    tog      = (k_q < KW'(STEPS));
    shift_ev = early ? (!lead && k_q < KW'(STEPS - 2)) : (lead && tog);
    if (early) samp_ev = smp_end ? !lead : lead;
    else       samp_ev = smp_end ? (lead && k_q != '0) : !lead;
    last     = (!early && smp_end) ? KW'(STEPS) : KW'(STEPS - 1);
    rx_next  = {rx_q[W-2:0], sdi};
    done     = run_q && step && (k_q == last);
    rx_byte  = samp_ev ? rx_next : rx_q;

    run_d = run_q;
    act_d = act_q;
    k_d   = k_q;
    tx_d  = tx_q;
    rx_d  = rx_q;
    sdo_d = sdo_q;
    if (start) begin
      run_d = 1'b1;
      act_d = 1'b0;
      k_d   = '0;
      if (early) begin
        sdo_d = tx_load[W-1];
        tx_d  = {tx_load[W-2:0], 1'b0};
      end else begin
        tx_d  = tx_load;
      end
    end else if (run_q && step) begin
      k_d = k_q + 1'b1;
      if (tog) act_d = ~act_q;
      if (shift_ev) begin
        sdo_d = tx_q[W-1];
        tx_d  = {tx_q[W-2:0], 1'b0};
      end
      if (samp_ev) rx_d = rx_next;
      if (done) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      act_q <= 1'b0;
      k_q   <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      run_q <= run_d;
      act_q <= act_d;
      k_q   <= k_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      sdo_q <= sdo_d;
    end
  end

  assign run  = run_q;
  assign sclk = cpol ^ act_q;
  assign sdo  = sdo_q;

  // R4: with early output, bit 7 is on the line right after the start
  p_sdo_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_q) && early) |-> (sdo_q == $past(tx_load[W-1])));
  // R3: a finished transfer leaves the clock phase at rest
  p_phase_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> !act_q);
endmodule

// File: rtl/spim_master.sv
// Top: receive buffer, flags, output enable.
module spim_master
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_A = 2,
  parameter int HALF_B = 8,
  parameter int HALF_C = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_early,
  input  logic              cfg_smp_end,
  input  logic [1:0]        cfg_rate,
  input  logic              cfg_rx_only,
  input  logic              tmr_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              irq_clr,
  input  logic              wcol_clr,
  input  logic              ovf_clr,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              irq,
  output logic              wcol,
  output logic              ovf
);
  logic              start, step, done, run;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              full_q, full_d, irq_q, irq_d, wcol_q, wcol_d, ovf_q, ovf_d;

  assign start = wr_en && !run;

  spim_clkgen #(.HALF_A(HALF_A), .HALF_B(HALF_B), .HALF_C(HALF_C)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(rate_e'(cfg_rate)),
    .tmr_tick(tmr_tick), .step(step)
  );

  spim_shifter #(.W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_load(wr_data), .step(step),
    .cpol(cfg_cpol), .early(cfg_early), .smp_end(cfg_smp_end), .sdi(sdi),
    .run(run), .sclk(sclk), .sdo(sdo), .done(done), .rx_byte(rx_byte)
  );

  always_comb begin
    buf_d  = buf_q;
    full_d = full_q;
    if (rd_en) full_d = 1'b0;
    if (done && !full_q) begin
      buf_d  = rx_byte;
      full_d = 1'b1;
    end
    irq_d  = done ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
    wcol_d = (wr_en && run) ? 1'b1 : (wcol_clr ? 1'b0 : wcol_q);
    ovf_d  = (done && full_q) ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      wcol_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      irq_q  <= irq_d;
      wcol_q <= wcol_d;
      ovf_q  <= ovf_d;
    end
  end

  assign rd_data = buf_q;
  assign busy    = run;
  assign irq     = irq_q;
  assign wcol    = wcol_q;
  assign ovf     = ovf_q;
  assign sdo_oe  = !cfg_rx_only;

  // R3: clock rests at the polarity level between transfers
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_cpol));
  // R9: write during a transfer raises the collision flag
  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wcol);
  // R10: overflow keeps the older byte
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full_q) |=> (ovf && $stable(rd_data)));
  // R8: completion into an empty buffer stores the byte and raises irq
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !full_q) |=> (irq && rd_data == $past(rx_byte) && !busy));
  // R11: irq holds until cleared
  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

// File: tb/spim_master_test.sv
module spim_master_test;
  localparam int TPER = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_early = 1'b0, cfg_smp_end = 1'b0, cfg_rx_only = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic       tmr_tick = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, irq_clr = 1'b0, wcol_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sdi = 1'b0;
  logic       sclk, sdo, sdo_oe, busy, irq, wcol, ovf;
  logic [7:0] rd_data;

  int nchk = 0, nfail = 0;
  bit bfull = 0;

  always #2 clk = ~clk;

  spim_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_early(cfg_early),
    .cfg_smp_end(cfg_smp_end), .cfg_rate(cfg_rate), .cfg_rx_only(cfg_rx_only),
    .tmr_tick(tmr_tick), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .irq_clr(irq_clr), .wcol_clr(wcol_clr), .ovf_clr(ovf_clr), .sdi(sdi),
    .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .rd_data(rd_data), .busy(busy),
    .irq(irq), .wcol(wcol), .ovf(ovf)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tmr_tick = (tc == TPER - 1);
      tc = (tc == TPER - 1) ? 0 : tc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_sample(int k, bit e, bit s);
    if (e) return s ? (k % 2 == 1) : (k % 2 == 0);
    return s ? (k % 2 == 0 && k >= 2) : (k % 2 == 1);
  endfunction

  function automatic bit is_cap(int k, bit e);
    return e ? (k % 2 == 0) : (k % 2 == 1);
  endfunction

  function automatic int exp_half(logic [1:0] r);
    case (r)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 32;
      default: return TPER;
    endcase
  endfunction

  task automatic xfer(input logic [7:0] txb, input logic [7:0] slvb, input bit e,
                      input bit s, input bit p, input logic [1:0] r, input bit rxo,
                      input int collide_at);
    logic [7:0] prev_rd, cap;
    logic       prev_sdo, prev_clk;
    int edges = 0, cyc = 0, idx = 0, t0 = 0, t1 = 0;
    bit did = 0, load;
    @(negedge clk);
    cfg_early = e; cfg_smp_end = s; cfg_cpol = p; cfg_rate = r; cfg_rx_only = rxo;
    sdi = slvb[7];
    prev_rd = rd_data; prev_sdo = sdo; load = !bfull; cap = 8'h00;
    wr_en = 1'b1; wr_data = txb;
    @(negedge clk);
    wr_en = 1'b0;
    chk(busy == 1'b1, "R1 busy after write", busy, 1);
    chk(rd_data == prev_rd, "R1 rd_data kept", rd_data, prev_rd);
    if (e) chk(sdo == txb[7], "R4 early bit7", sdo, txb[7]);
    else   chk(sdo == prev_sdo, "R5 sdo held before first edge", sdo, prev_sdo);
    prev_clk = sclk;
    while (busy && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      wr_en = 1'b0;
      if (sclk !== prev_clk) begin
        int k = edges;
        edges++;
        prev_clk = sclk;
        if (k == 0) t0 = cyc;
        if (k == 1) t1 = cyc;
        if (is_cap(k, e)) cap = {cap[6:0], sdo};
        if (is_sample(k, e, s)) begin
          idx++;
          if (idx < 8) sdi = slvb[7 - idx];
        end
      end
      if (collide_at >= 0 && edges == collide_at && !did && busy) begin
        wr_en = 1'b1; wr_data = ~txb; did = 1;
      end
    end
    wr_en = 1'b0;
    chk(cyc < 6000, "R8 transfer finished", cyc, 0);
    chk(edges == 16, "R3 edge count", edges, 16);
    chk(sclk == p, "R3 rest level after", sclk, p);
    chk(t1 - t0 == exp_half(r), "R2 half period", t1 - t0, exp_half(r));
    chk(sdo_oe == !rxo, "R12 output enable", sdo_oe, !rxo);
    if (!rxo) chk(cap == txb, e ? "R4 R7 sent byte" : "R5 R7 sent byte", cap, txb);
    chk(sdo == txb[0], "R5 sdo holds bit0", sdo, txb[0]);
    chk(irq == 1'b1, "R8 irq set", irq, 1);
    if (load) chk(rd_data == slvb, rxo ? "R12 R6 R7 received" : "R6 R7 received", rd_data, slvb);
    else begin
      chk(rd_data == prev_rd, "R10 older byte kept", rd_data, prev_rd);
      chk(ovf == 1'b1, "R10 ovf set", ovf, 1);
    end
    if (did) chk(wcol == 1'b1, "R9 wcol set", wcol, 1);
    bfull = 1;
  endtask

  task automatic drain();
    @(negedge clk);
    rd_en = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; irq_clr = 1'b0;
    chk(irq == 1'b0, "R11 irq cleared", irq, 0);
    bfull = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(irq == 0 && wcol == 0 && ovf == 0, "R11 reset flags", {irq, wcol, ovf}, 0);
    chk(sclk == 1'b0, "R3 reset rest level", sclk, 0);
    chk(rd_data == 8'h00, "R8 reset buffer", rd_data, 0);

    // all four timing modes, both polarities
    xfer(8'hA5, 8'h3C, 1, 0, 0, 2'd0, 0, -1); drain();
    xfer(8'h3C, 8'hA5, 1, 1, 1, 2'd0, 0, -1); drain();
    xfer(8'hA5, 8'h96, 0, 0, 1, 2'd1, 0, -1); drain();
    xfer(8'h69, 8'hA5, 0, 1, 0, 2'd2, 0, -1); drain();
    xfer(8'hC3, 8'h5A, 0, 1, 1, 2'd3, 0, -1); drain();

    // overflow: two bytes without a read
    xfer(8'h11, 8'h81, 1, 0, 0, 2'd0, 0, -1);
    xfer(8'h22, 8'h42, 1, 0, 0, 2'd0, 0, -1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk(ovf == 0, "R11 ovf cleared", ovf, 0);
    chk(rd_data == 8'h81, "R10 buffer after clear", rd_data, 8'h81);
    drain();

    // collision in mid-transfer
    xfer(8'hE7, 8'h18, 0, 0, 0, 2'd1, 0, 5); drain();
    @(negedge clk); wcol_clr = 1'b1;
    @(negedge clk); wcol_clr = 1'b0;
    chk(wcol == 0, "R11 wcol cleared", wcol, 0);

    // receive-only
    xfer(8'h00, 8'hB4, 1, 1, 0, 2'd0, 1, -1); drain();

    for (int i = 0; i < 30; i++) begin
      logic [7:0] a = 8'($urandom);
      logic [7:0] b = 8'($urandom);
      logic [3:0] m = 4'($urandom);
      logic [1:0] r = 2'($urandom);
      xfer(a, b, m[0], m[1], m[2], r, m[3] & i[0], -1);
      drain();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule